// File: doc/BRIEF.md
# Belt Position Remapper

This block turns logical belt positions into physical operand tags for a sixteen-entry operand belt. A circular array holds one tag per entry, and a moving origin marks which entry is currently position zero. Reading a position is a single indexed lookup relative to that origin. Each clock the block can take a batch of newly created operands. It hands out their tags from an internal take-a-number counter, puts them at the low positions and shifts every older operand up by the batch size.

Carrying branches and calls use a bulk remap. The operation lists belt positions. Each listed position is looked up in the map as it stands before the remap, and the looked-up tags are then dropped as one ordinary batch, so the target code sees the carried operands at positions 0 upward. Lookups are combinational and always show the mapping from before the current edge. All updates land at the next rising clock edge.

Top module: `belt_remapper`

## Requirements
- R1: After reset every belt position reads as invalid.
- R2: Read ports are combinational. Inside a cycle they return the mapping from before that cycle's drop or remap, and the change is visible only after the next rising edge.
- R3: A drop of n operands puts the new operands at positions 0 to n-1, list element k at position k. An operand that was at position p moves to position p+n. Operands pushed past position 15 are discarded.
- R4: Tags come from a modulo-16 counter that starts at 0 after reset. In a drop, element k gets tag base+k. The counter then moves forward by the number of operands dropped.
- R5: Any drop or remap count above 16 is handled as 16.
- R6: A drop count of 0 with no remap leaves every position's tag and validity unchanged.
- R7: A bulk remap of n entries sets new position k to the tag and validity that listed source position k held before the remap, for every k below n. Sources and destinations may overlap or repeat. Older operands then shift by n, as for an ordinary drop.
- R8: While a remap is requested, the drop count is ignored and no tags are allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| drop_cnt_i | input | 5 | Number of new operands created this cycle |
| remap_en_i | input | 1 | Perform a bulk remap this cycle |
| remap_cnt_i | input | 5 | Number of entries in the remap list |
| remap_pos_i | input | 64 | Remap source positions; entry k is in bits [4k+3:4k] |
| rd_pos_i | input | 8 | Read positions; port j is in bits [4j+3:4j] |
| rd_tag_o | output | 8 | Physical tags; port j is in bits [4j+3:4j] |
| rd_vld_o | output | 2 | Bit j is set when port j's position holds a live operand |

## Verification
A wrong origin shows up after just one drop: every older position reads a neighbour's tag, or a slot that should hold a value reads as invalid. A slipped allocator shows up as wrong tags at position 0 right after the next creating drop. A remap that reads the map after it has been partly written shows up only when sources overlap destinations, so directed overlapping remaps are mixed in with the random ones. The bench compares every position after every cycle, so any error shows up in the cycle that follows the faulty edge.

// File: rtl/belt_pkg.sv
`timescale 1ns/1ps
package belt_pkg;
  localparam int unsigned BELT_LEN = 16;

  // position/slot arithmetic on the ring
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned len);
    return (a + b) % len;
  endfunction

  function automatic int unsigned ring_sub(int unsigned a, int unsigned b, int unsigned len);
    return (a + len - (b % len)) % len;
  endfunction

  function automatic int unsigned clamp_cnt(int unsigned cnt, int unsigned len);
    return (cnt > len) ? len : cnt;
  endfunction
endpackage

// File: rtl/belt_tag_alloc.sv
`timescale 1ns/1ps
module belt_tag_alloc
  import belt_pkg::*;
#(
  parameter int unsigned LEN = belt_pkg::BELT_LEN,
  localparam int unsigned POS_W = $clog2(LEN),
  localparam int unsigned CNT_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] alloc_n,
  output logic [POS_W-1:0] base_o
);
  logic [POS_W-1:0] take_q;

  always_ff @(posedge clk) begin
    if (!rst_n) take_q <= '0;
    else        take_q <= POS_W'(ring_add(32'(take_q), 32'(alloc_n), LEN));
  end

  assign base_o = take_q;
endmodule

// File: rtl/belt_drop_builder.sv
`timescale 1ns/1ps
module belt_drop_builder
  import belt_pkg::*;
#(
  parameter int unsigned LEN = belt_pkg::BELT_LEN,
  localparam int unsigned POS_W = $clog2(LEN),
  localparam int unsigned CNT_W = POS_W + 1
) (
  input  logic [CNT_W-1:0]     drop_cnt,
  input  logic                 remap_en,
  input  logic [CNT_W-1:0]     remap_cnt,
  input  logic [LEN*POS_W-1:0] remap_pos,
  input  logic [POS_W-1:0]     alloc_base,
  input  logic [LEN*POS_W-1:0] map_tag,
  input  logic [LEN-1:0]       map_vld,
  input  logic [POS_W-1:0]     origin,
  output logic [LEN*POS_W-1:0] list_tag,
  output logic [LEN-1:0]       list_vld,
  output logic [CNT_W-1:0]     drop_n,
  output logic [CNT_W-1:0]     alloc_n
);
  logic [CNT_W-1:0] fresh_n;
  logic [CNT_W-1:0] carry_n;

  assign fresh_n = CNT_W'(clamp_cnt(32'(drop_cnt), LEN));
  assign carry_n = CNT_W'(clamp_cnt(32'(remap_cnt), LEN));
  assign drop_n  = remap_en ? carry_n : fresh_n;
  assign alloc_n = remap_en ? '0 : fresh_n;

  // zero-origin list: translated sources for a remap, fresh tags otherwise
  always_comb begin
    int unsigned slot;
    for (int unsigned k = 0; k < LEN; k++) begin
      slot = ring_add(32'(remap_pos[k*POS_W +: POS_W]), 32'(origin), LEN);
      if (remap_en) begin
        list_tag[k*POS_W +: POS_W] = map_tag[slot*POS_W +: POS_W];
        list_vld[k]                = map_vld[slot];
      end else begin
        list_tag[k*POS_W +: POS_W] = POS_W'(ring_add(32'(alloc_base), k, LEN));
        list_vld[k]                = 1'b1;
      end
    end
  end
endmodule

// File: rtl/belt_map_array.sv
`timescale 1ns/1ps
module belt_map_array
  import belt_pkg::*;
#(
  parameter int unsigned LEN = belt_pkg::BELT_LEN,
  parameter int unsigned RD_PORTS = 2,
  localparam int unsigned POS_W = $clog2(LEN),
  localparam int unsigned CNT_W = POS_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          drop_n,
  input  logic [LEN*POS_W-1:0]      list_tag,
  input  logic [LEN-1:0]            list_vld,
  input  logic [RD_PORTS*POS_W-1:0] rd_pos,
  output logic [RD_PORTS*POS_W-1:0] rd_tag,
  output logic [RD_PORTS-1:0]       rd_vld,
  output logic [LEN*POS_W-1:0]      map_tag,
  output logic [LEN-1:0]            map_vld,
  output logic [POS_W-1:0]          origin
);
  logic [POS_W-1:0] tag_q [LEN];
  logic [POS_W-1:0] tag_d [LEN];
  logic [LEN-1:0]   vld_q;
  logic [LEN-1:0]   vld_d;
  logic [POS_W-1:0] origin_q;
  logic [POS_W-1:0] origin_d;

  // origin steps back so the newest operand lands at position 0
  assign origin_d = POS_W'(ring_sub(32'(origin_q), 32'(drop_n), LEN));

  always_comb begin
    int unsigned k;
    for (int unsigned i = 0; i < LEN; i++) begin
      k = ring_sub(i, 32'(origin_d), LEN);
      if (k < 32'(drop_n)) begin
        tag_d[i] = list_tag[k*POS_W +: POS_W];
        vld_d[i] = list_vld[k];
      end else begin
        tag_d[i] = tag_q[i];
        vld_d[i] = vld_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      origin_q <= '0;
      vld_q    <= '0;
      for (int unsigned i = 0; i < LEN; i++) tag_q[i] <= '0;
    end else begin
      origin_q <= origin_d;
      vld_q    <= vld_d;
      for (int unsigned i = 0; i < LEN; i++) tag_q[i] <= tag_d[i];
    end
  end

  for (genvar g = 0; g < LEN; g++) begin : g_flat
    assign map_tag[g*POS_W +: POS_W] = tag_q[g];
  end
  assign map_vld = vld_q;
  assign origin  = origin_q;

  for (genvar j = 0; j < RD_PORTS; j++) begin : g_rd
    logic [POS_W-1:0] slot;
    assign slot = POS_W'(ring_add(32'(rd_pos[j*POS_W +: POS_W]), 32'(origin_q), LEN));
    assign rd_tag[j*POS_W +: POS_W] = tag_q[slot];
    assign rd_vld[j] = vld_q[slot];
  end
endmodule

// File: rtl/belt_remapper.sv
`timescale 1ns/1ps
module belt_remapper #(
  parameter int unsigned BELT_LEN = 16,
  parameter int unsigned RD_PORTS = 2,
  localparam int unsigned POS_W = $clog2(BELT_LEN),
  localparam int unsigned CNT_W = POS_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          drop_cnt_i,
  input  logic                      remap_en_i,
  input  logic [CNT_W-1:0]          remap_cnt_i,
  input  logic [BELT_LEN*POS_W-1:0] remap_pos_i,
  input  logic [RD_PORTS*POS_W-1:0] rd_pos_i,
  output logic [RD_PORTS*POS_W-1:0] rd_tag_o,
  output logic [RD_PORTS-1:0]       rd_vld_o
);
  // named internal events, used by the bound checker
  logic [CNT_W-1:0]          drop_n;
  logic [CNT_W-1:0]          alloc_n;
  logic [POS_W-1:0]          alloc_base;
  logic [POS_W-1:0]          origin;
  logic [BELT_LEN*POS_W-1:0] map_tag;
  logic [BELT_LEN-1:0]       map_vld;
  logic [BELT_LEN*POS_W-1:0] list_tag;
  logic [BELT_LEN-1:0]       list_vld;

  belt_tag_alloc #(.LEN(BELT_LEN)) u_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_n(alloc_n), .base_o(alloc_base)
  );

  belt_drop_builder #(.LEN(BELT_LEN)) u_build (
    .drop_cnt(drop_cnt_i), .remap_en(remap_en_i), .remap_cnt(remap_cnt_i),
    .remap_pos(remap_pos_i), .alloc_base(alloc_base), .map_tag(map_tag),
    .map_vld(map_vld), .origin(origin), .list_tag(list_tag),
    .list_vld(list_vld), .drop_n(drop_n), .alloc_n(alloc_n)
  );

  belt_map_array #(.LEN(BELT_LEN), .RD_PORTS(RD_PORTS)) u_map (
    .clk(clk), .rst_n(rst_n), .drop_n(drop_n), .list_tag(list_tag),
    .list_vld(list_vld), .rd_pos(rd_pos_i), .rd_tag(rd_tag_o),
    .rd_vld(rd_vld_o), .map_tag(map_tag), .map_vld(map_vld), .origin(origin)
  );
endmodule

// File: rtl/belt_remapper_chk.sv
`timescale 1ns/1ps
module belt_remapper_chk
  import belt_pkg::*;
#(
  parameter int unsigned BELT_LEN = 16,
  localparam int unsigned POS_W = $clog2(BELT_LEN),
  localparam int unsigned CNT_W = POS_W + 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      remap_en_i,
  input logic [CNT_W-1:0]          drop_n,
  input logic [CNT_W-1:0]          alloc_n,
  input logic [POS_W-1:0]          alloc_base,
  input logic [POS_W-1:0]          origin,
  input logic [BELT_LEN*POS_W-1:0] map_tag,
  input logic [BELT_LEN-1:0]       map_vld
);
  assert_origin_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> origin == POS_W'(ring_sub(32'($past(origin)), 32'($past(drop_n)), BELT_LEN)));

  assert_alloc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> alloc_base == POS_W'(ring_add(32'($past(alloc_base)), 32'($past(alloc_n)), BELT_LEN)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(drop_n) <= BELT_LEN);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_n == '0 |=> $stable(map_tag) && $stable(map_vld) && $stable(origin));

  assert_full_drop_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(drop_n) == BELT_LEN && !remap_en_i) |=> &map_vld);

  assert_remap_no_alloc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    remap_en_i |=> $stable(alloc_base));
endmodule

bind belt_remapper belt_remapper_chk #(.BELT_LEN(BELT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .remap_en_i(remap_en_i), .drop_n(drop_n),
  .alloc_n(alloc_n), .alloc_base(alloc_base), .origin(origin),
  .map_tag(map_tag), .map_vld(map_vld)
);

// File: tb/belt_remapper_bench.sv
`timescale 1ns/1ps
module belt_remapper_bench;
  localparam int LEN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  drop_cnt = '0;
  logic        remap_en = 1'b0;
  logic [4:0]  remap_cnt = '0;
  logic [63:0] remap_pos = '0;
  logic [7:0]  rd_pos = '0;
  logic [7:0]  rd_tag;
  logic [1:0]  rd_vld;

  int checks = 0;
  int errors = 0;

  // shift-based model: index is the belt position itself
  int m_tag [LEN];
  bit m_vld [LEN];
  int m_take;

  always #2 clk = ~clk;

  belt_remapper u_belt_remapper (
    .clk(clk), .rst_n(rst_n), .drop_cnt_i(drop_cnt), .remap_en_i(remap_en),
    .remap_cnt_i(remap_cnt), .remap_pos_i(remap_pos), .rd_pos_i(rd_pos),
    .rd_tag_o(rd_tag), .rd_vld_o(rd_vld)
  );

  function automatic int eff_cnt(int c);
    return (c > LEN) ? LEN : c;
  endfunction

  function automatic void model_step(int dc, bit ren, int rc, logic [63:0] rp);
    int n;
    int lt [LEN];
    bit lv [LEN];
    int ot [LEN];
    bit ov [LEN];
    n = ren ? eff_cnt(rc) : eff_cnt(dc);
    for (int p = 0; p < LEN; p++) begin ot[p] = m_tag[p]; ov[p] = m_vld[p]; end
    for (int k = 0; k < LEN; k++) begin
      if (ren) begin lt[k] = ot[int'(rp[k*4 +: 4])]; lv[k] = ov[int'(rp[k*4 +: 4])]; end
      else     begin lt[k] = (m_take + k) % LEN;     lv[k] = 1'b1; end
    end
    for (int p = 0; p < LEN; p++) begin
      if (p < n) begin m_tag[p] = lt[p];   m_vld[p] = lv[p];   end
      else       begin m_tag[p] = ot[p-n]; m_vld[p] = ov[p-n]; end
    end
    if (!ren) m_take = (m_take + n) % LEN;
  endfunction

  task automatic cmp(string req, int pos, bit v, int t);
    checks++;
    if (v !== m_vld[pos] || (m_vld[pos] && t != m_tag[pos])) begin
      errors++;
      $display("FAIL %s pos %0d: got vld=%0d tag=%0d, expected vld=%0d tag=%0d",
               req, pos, v, t, m_vld[pos], m_tag[pos]);
    end
  endtask

  task automatic check_all(string req);
    for (int p = 0; p < LEN; p += 2) begin
      rd_pos = {4'(p + 1), 4'(p)};
      #0.1;
      cmp(req, p, rd_vld[0], int'(rd_tag[3:0]));
      cmp(req, p + 1, rd_vld[1], int'(rd_tag[7:4]));
    end
  endtask

  task automatic step(string req, int dc, bit ren, int rc, logic [63:0] rp);
    @(negedge clk);
    drop_cnt = 5'(dc); remap_en = ren; remap_cnt = 5'(rc); remap_pos = rp;
    rd_pos = 8'h10;
    #0.2;
    cmp("R2", 0, rd_vld[0], int'(rd_tag[3:0]));   // old mapping still visible
    @(posedge clk);
    model_step(dc, ren, rc, rp);
    #0.1;
    drop_cnt = '0; remap_en = 1'b0; remap_cnt = '0; remap_pos = '0;
    check_all(req);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int p = 0; p < LEN; p++) begin m_tag[p] = 0; m_vld[p] = 1'b0; end
    m_take = 0;
    repeat (3) @(posedge clk);
    #0.1 rst_n = 1'b1;
    check_all("R1");
    step("R3_R4", 3, 1'b0, 0, '0);
    step("R6", 0, 1'b0, 0, '0);
    step("R3", 5, 1'b0, 0, '0);
    step("R7", 0, 1'b1, 4, 64'h0000_0000_0000_F003);  // overlap, repeat, invalid src
    step("R8", 7, 1'b1, 2, 64'h0000_0000_0000_0012);
    step("R5", 23, 1'b0, 0, '0);
    step("R7", 0, 1'b1, 16, 64'h0123_4567_89AB_CDEF);  // full reversal
    step("R5", 0, 1'b1, 30, 64'hFEDC_BA98_7654_3210);
    step("R3", 16, 1'b0, 0, '0);
    for (int i = 0; i < 300; i++) begin
      logic [63:0] rp;
      bit ren;
      rp  = {$urandom, $urandom};
      ren = ($urandom % 4) == 0;
      if (ren) step("R7", int'($urandom % 20), 1'b1, int'($urandom % 18), rp);
      else     step("R3", int'($urandom % 19), 1'b0, 0, rp);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule